// File: doc/BRIEF.md
# Template-Driven Bundle Issue Unit

This unit takes fixed-size 128-bit instruction bundles and turns each one into one or more issue groups. A bundle carries an 8-bit grouping template and three 40-bit instruction slots. The compiler has already decided which slots may run side by side and written that decision into the template. The unit therefore does no dependency analysis of its own. It only reads the stop marks in the template, splits each slot into its fields, and sends every group to three execution lanes, one group per cycle, in slot order.

Every slot holds a real instruction. A stop mark, not a filler operation, is what keeps two slots out of the same cycle. Bundles arrive on a valid/ready handshake. The unit holds one bundle at a time and refuses the next one until the last group of the current bundle is being issued.

The template can also mark a bundle as chainable. In that case its last group may share a cycle with the first group of the following bundle, provided the three lanes have room for both.

Top module: `bundle_issue`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, all lane valid flags are low and `in_ready` is high.
- R2: A bundle is taken on a clock edge where `in_valid` and `in_ready` are both high. If the unit held no bundle before that edge, the bundle's first group appears on the lanes in the following cycle.
- R3: The bundle layout is fixed. The template is bits [127:120]. Slot 0 is [119:80], slot 1 is [79:40] and slot 2 is [39:0]. Within a slot, the predicate tag is [39:34], the register specifiers A, B and C are [33:27], [26:20] and [19:13], and the opcode is [12:0]. Each lane presents these fields unchanged.
- R4: When template bits [1:0] are 00, all three slots issue in one cycle. Slots 0, 1 and 2 go to lanes 0, 1 and 2.
- R5: Template bit 0 ends a group after slot 0, and template bit 1 ends a group after slot 1. The groups issue in consecutive cycles in slot order. The slots of a group fill the lanes from lane 0 upward, and the lanes above them stay invalid.
- R6: `in_ready` is low in every cycle where the held bundle still has a group left to issue after the current one. A bundle offered in such a cycle is not taken, and the held bundle's groups continue.
- R7: `in_ready` is high in the cycle where the held bundle's last group issues. A bundle offered then is taken, and its first group issues in the next cycle, so no idle cycle separates the two bundles.
- R8: When template bit 2 of the held bundle is set, and its last group is issuing, and `in_valid` is high, and the last group plus the next bundle's first group fit in three lanes, then both issue in the same cycle. The next bundle's slots take the lanes just above the held group. The next bundle is taken on that edge, and its remaining groups follow from the next cycle.
- R9: If template bit 2 is clear, or the two groups together exceed three lanes, nothing is merged. The next bundle's first group then issues in the cycle after the one in which the bundle was taken.
- R10: Template bits [7:3] have no effect on grouping or issue.
- R11: Every slot of every bundle taken is issued exactly once, so the number of valid lane flags summed over a bundle's cycles is three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Bundle offered |
| in_ready | output | 1 | Unit can take a bundle on this edge |
| in_bundle | input | 128 | Template and three instruction slots |
| lane_vld | output | 3 | Per-lane issue flag, lane 0 in bit 0 |
| lane_pred | output | 3x6 | Per-lane predicate tag |
| lane_ra | output | 3x7 | Per-lane register specifier A |
| lane_rb | output | 3x7 | Per-lane register specifier B |
| lane_rc | output | 3x7 | Per-lane register specifier C |
| lane_op | output | 3x13 | Per-lane opcode |

## Verification
The assertions take for granted that `in_valid` always carries a known level, and that reset is held over at least one clock edge before the first bundle arrives. Given that, they expect the lane flags to stay packed from lane 0, and they expect a held bundle never to keep `in_ready` low for more than two cycles in a row. The stimulus changes inputs only on the falling clock edge and always drives defined values. Once a check is done it lowers `in_valid` unless the scenario is testing chaining, back-to-back issue or an offer that must be refused.

// File: rtl/bundle_issue.sv
module bundle_issue #(
  parameter int PRED_W = 6,
  parameter int REG_W  = 7,
  parameter int OP_W   = 13
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [127:0]          in_bundle,
  output logic [2:0]            lane_vld,
  output logic [2:0][PRED_W-1:0] lane_pred,
  output logic [2:0][REG_W-1:0]  lane_ra,
  output logic [2:0][REG_W-1:0]  lane_rb,
  output logic [2:0][REG_W-1:0]  lane_rc,
  output logic [2:0][OP_W-1:0]   lane_op
);

  localparam int SLOT_W = PRED_W + 3 * REG_W + OP_W;

  logic         hold_q;
  logic [127:0] bund_q;
  logic [1:0]   start_q;

  function automatic logic [1:0] grp_end(input logic [1:0] stops, input logic [1:0] from);
    logic [1:0] e;
    case (from)
      2'd0:    e = stops[0] ? 2'd0 : (stops[1] ? 2'd1 : 2'd2);
      2'd1:    e = stops[1] ? 2'd1 : 2'd2;
      default: e = 2'd2;
    endcase
    return e;
  endfunction

  function automatic logic [SLOT_W-1:0] slot_of(input logic [127:0] b, input logic [1:0] i);
    logic [SLOT_W-1:0] w;
    case (i)
      2'd0:    w = b[119:80];
      2'd1:    w = b[79:40];
      default: w = b[39:0];
    endcase
    return w;
  endfunction

  logic [1:0] cur_end, nxt_end;
  logic [2:0] cur_cnt, nxt_cnt;
  logic       on_last, chain, fire;

  assign cur_end = grp_end(bund_q[121:120], start_q);
  assign cur_cnt = {1'b0, cur_end} - {1'b0, start_q} + 3'd1;
  assign nxt_end = grp_end(in_bundle[121:120], 2'd0);
  assign nxt_cnt = {1'b0, nxt_end} + 3'd1;
  assign on_last = hold_q && (cur_end == 2'd2);
  assign in_ready = !hold_q || (cur_end == 2'd2);
  assign fire    = in_valid && in_ready;
  assign chain   = on_last && bund_q[122] && in_valid && ((cur_cnt + nxt_cnt) <= 3'd3);

  logic [2:0][SLOT_W-1:0] word;

  always_comb begin
    for (int k = 0; k < 3; k++) begin
      word[k]     = '0;
      lane_vld[k] = 1'b0;
      if (hold_q && 3'(k) < cur_cnt) begin
        word[k]     = slot_of(bund_q, start_q + 2'(k));
        lane_vld[k] = 1'b1;
      end else if (chain && 3'(k) < cur_cnt + nxt_cnt) begin
        word[k]     = slot_of(in_bundle, 2'(3'(k) - cur_cnt));
        lane_vld[k] = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < 3; g++) begin : g_lane
    assign lane_pred[g] = word[g][SLOT_W-1 -: PRED_W];
    assign lane_ra[g]   = word[g][OP_W+3*REG_W-1 -: REG_W];
    assign lane_rb[g]   = word[g][OP_W+2*REG_W-1 -: REG_W];
    assign lane_rc[g]   = word[g][OP_W+REG_W-1 -: REG_W];
    assign lane_op[g]   = word[g][OP_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q  <= 1'b0;
      bund_q  <= '0;
      start_q <= 2'd0;
    end else if (fire) begin
      hold_q  <= 1'b1;
      bund_q  <= in_bundle;
      start_q <= chain ? nxt_end + 2'd1 : 2'd0;
    end else if (on_last) begin
      hold_q  <= 1'b0;
    end else if (hold_q) begin
      start_q <= cur_end + 2'd1;
    end
  end

  // R5: issued slots always fill lanes from lane 0 upward
  a_r5_lanes_packed: assert property (@(posedge clk) disable iff (!rst_n)
    lane_vld == 3'b000 || lane_vld == 3'b001 || lane_vld == 3'b011 || lane_vld == 3'b111);

  // R2: a bundle taken from idle issues its first group on the next cycle
  a_r2_issue_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && lane_vld == 3'b000) |=> lane_vld[0]);

  // R6: while a bundle blocks intake, lanes are busy
  a_r6_blocked_means_issuing: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> lane_vld[0]);

  // R6: a bundle has at most three groups, so intake is never blocked three cycles running
  a_r6_block_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && $past(!in_ready)) |=> in_ready);

endmodule

// File: tb/bundle_issue_tb.sv
module bundle_issue_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [127:0] in_bundle = '0;
  logic [2:0] lane_vld;
  logic [2:0][5:0] lane_pred;
  logic [2:0][6:0] lane_ra, lane_rb, lane_rc;
  logic [2:0][12:0] lane_op;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bundle_issue u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bundle(in_bundle), .lane_vld(lane_vld), .lane_pred(lane_pred),
    .lane_ra(lane_ra), .lane_rb(lane_rb), .lane_rc(lane_rc), .lane_op(lane_op)
  );

  function automatic logic [127:0] mk(input logic [7:0] t, input logic [39:0] a, b, c);
    return {t, a, b, c};
  endfunction

  function automatic logic [39:0] sw(input int n);
    return {6'(n), 7'(n + 11), 7'(n + 23), 7'(n + 37), 13'(n * 97 + 5)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [127:0] b, input logic er,
                      input logic [2:0] ev, input logic [39:0] w0, w1, w2, input string req);
    logic [39:0] got;
    logic [2:0][39:0] ew;
    ew[0] = w0; ew[1] = w1; ew[2] = w2;
    @(negedge clk);
    in_valid = v;
    in_bundle = b;
    #1;
    chk(in_ready == er, {req, " ready"}, 64'(in_ready), 64'(er));
    chk(lane_vld == ev, {req, " lane_vld"}, 64'(lane_vld), 64'(ev));
    for (int k = 0; k < 3; k++) begin
      if (ev[k]) begin
        got = {lane_pred[k], lane_ra[k], lane_rb[k], lane_rc[k], lane_op[k]};
        chk(got == ew[k], {req, " lane word"}, 64'(got), 64'(ew[k]));
      end
    end
  endtask

  task automatic t_reset;
    #1;
    chk(lane_vld == 3'b000 && in_ready, "R1 in reset", 64'({in_ready, lane_vld}), 64'h8);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    step(0, '0, 1, 3'b000, 0, 0, 0, "R1");
  endtask

  task automatic t_fields;
    logic [127:0] b;
    b = mk(8'h00, {6'h2a, 7'h11, 7'h22, 7'h33, 13'h1abc}, sw(3), sw(4));
    step(1, b, 1, 3'b000, 0, 0, 0, "R2 take");
    step(0, '0, 1, 3'b111, b[119:80], sw(3), sw(4), "R4");
    chk(lane_pred[0] == 6'h2a && lane_ra[0] == 7'h11 && lane_rb[0] == 7'h22 &&
        lane_rc[0] == 7'h33 && lane_op[0] == 13'h1abc, "R3 fields",
        64'({lane_pred[0], lane_op[0]}), 64'({6'h2a, 13'h1abc}));
    step(0, '0, 1, 3'b000, 0, 0, 0, "R2 idle");
  endtask

  task automatic t_stops;
    int issued = 0;
    step(1, mk(8'h01, sw(10), sw(11), sw(12)), 1, 3'b000, 0, 0, 0, "R2");
    step(0, '0, 0, 3'b001, sw(10), 0, 0, "R5 stop0 g0");
    step(0, '0, 1, 3'b011, sw(11), sw(12), 0, "R5 stop0 g1");
    step(1, mk(8'h02, sw(20), sw(21), sw(22)), 1, 3'b000, 0, 0, 0, "R2");
    step(0, '0, 0, 3'b011, sw(20), sw(21), 0, "R5 stop1 g0");
    step(0, '0, 1, 3'b001, sw(22), 0, 0, "R5 stop1 g1");
    step(1, mk(8'h03, sw(30), sw(31), sw(32)), 1, 3'b000, 0, 0, 0, "R2");
    step(0, '0, 0, 3'b001, sw(30), 0, 0, "R5 both g0");
    issued += $countones(lane_vld);
    step(1, mk(8'h00, sw(90), sw(91), sw(92)), 0, 3'b001, sw(31), 0, 0, "R6 refused offer");
    issued += $countones(lane_vld);
    step(0, '0, 1, 3'b001, sw(32), 0, 0, "R5 both g2");
    issued += $countones(lane_vld);
    chk(issued == 3, "R11 slot count", 64'(issued), 64'd3);
    step(0, '0, 1, 3'b000, 0, 0, 0, "R6 offer not taken");
  endtask

  task automatic t_back_to_back;
    step(1, mk(8'h01, sw(40), sw(41), sw(42)), 1, 3'b000, 0, 0, 0, "R2");
    step(0, '0, 0, 3'b001, sw(40), 0, 0, "R5");
    step(1, mk(8'h00, sw(50), sw(51), sw(52)), 1, 3'b011, sw(41), sw(42), 0, "R7 take on last");
    step(0, '0, 1, 3'b111, sw(50), sw(51), sw(52), "R7 no bubble");
    step(0, '0, 1, 3'b000, 0, 0, 0, "R7 idle");
  endtask

  task automatic t_chain;
    step(1, mk(8'h05, sw(60), sw(61), sw(62)), 1, 3'b000, 0, 0, 0, "R2");
    step(0, '0, 0, 3'b001, sw(60), 0, 0, "R8 g0");
    step(1, mk(8'h01, sw(70), sw(71), sw(72)), 1, 3'b111, sw(61), sw(62), sw(70), "R8 merged 2+1");
    step(0, '0, 1, 3'b011, sw(71), sw(72), 0, "R8 rest");
    step(1, mk(8'h06, sw(80), sw(81), sw(82)), 1, 3'b000, 0, 0, 0, "R2");
    step(0, '0, 0, 3'b011, sw(80), sw(81), 0, "R8 g0");
    step(1, mk(8'h02, sw(83), sw(84), sw(85)), 1, 3'b111, sw(82), sw(83), sw(84), "R8 merged 1+2");
    step(0, '0, 1, 3'b001, sw(85), 0, 0, "R8 rest");
    step(0, '0, 1, 3'b000, 0, 0, 0, "R8 idle");
  endtask

  task automatic t_no_chain;
    step(1, mk(8'h06, sw(100), sw(101), sw(102)), 1, 3'b000, 0, 0, 0, "R2");
    step(0, '0, 0, 3'b011, sw(100), sw(101), 0, "R9 g0");
    step(1, mk(8'h00, sw(110), sw(111), sw(112)), 1, 3'b001, sw(102), 0, 0, "R9 too wide");
    step(0, '0, 1, 3'b111, sw(110), sw(111), sw(112), "R9 next");
    step(1, mk(8'h02, sw(120), sw(121), sw(122)), 1, 3'b000, 0, 0, 0, "R2");
    step(0, '0, 0, 3'b011, sw(120), sw(121), 0, "R9 g0");
    step(1, mk(8'h01, sw(130), sw(131), sw(132)), 1, 3'b001, sw(122), 0, 0, "R9 bit2 clear");
    step(0, '0, 0, 3'b001, sw(130), 0, 0, "R9 next g0");
    step(0, '0, 1, 3'b011, sw(131), sw(132), 0, "R9 next g1");
  endtask

  task automatic t_reserved;
    step(1, mk(8'hF8, sw(140), sw(141), sw(142)), 1, 3'b000, 0, 0, 0, "R10 take");
    step(0, '0, 1, 3'b111, sw(140), sw(141), sw(142), "R10 reserved ignored");
    step(1, mk(8'hA9, sw(150), sw(151), sw(152)), 1, 3'b000, 0, 0, 0, "R10 take");
    step(0, '0, 0, 3'b001, sw(150), 0, 0, "R10 reserved stop0");
    step(0, '0, 1, 3'b011, sw(151), sw(152), 0, "R10 reserved g1");
    step(0, '0, 1, 3'b000, 0, 0, 0, "R10 idle");
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    t_reset;
    t_fields;
    t_stops;
    t_back_to_back;
    t_chain;
    t_no_chain;
    t_reserved;
    finish_run;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run;
  end
endmodule